// File: doc/BRIEF.md
# Sixteen-bit register-machine instruction decoder

This block turns one fetched 16-bit instruction word into the control and field values that the rest of a small register-register processor needs. The machine has sixteen 16-bit general-purpose registers. The block drives three register selects, a 16-bit immediate, an ALU function code, register-file and memory enables, and branch and jump steering. It also flags encodings that are not assigned. It is purely combinational: the word on `instr_i` is decoded in the same cycle, with no state and no handshake. The fetch stage owns the timing.

The top four bits pick the primary group. Two groups, `0001` and `0011`, are widened by a function code in the low nibble. The other groups carry their operands in fixed positions. Fields that an instruction does not use are driven as zero. On an unassigned encoding every output is zero except the illegal flag. A downstream stage can therefore discard such a word without extra gating.

Top module: `rr16_decoder`

## Requirements
- R1: Fields: opcode [15:12], first register A [11:8], second register B [7:4], function [3:0]. ALU codes: 0 none, 1 add, 2 sub, 3 and, 4 or, 5 not, 6 shift left, 7 shift right, 8 pass B, 9 set-less-than. Opcode `0001` with function 0 (add) or 1 (sub): ra=A, rb=B, rd=A, full write (mask 11). Function 7 (move): rb=B, rd=A, pass B. Function 12 (compare): ra=A, rb=B, code 9, no write.
- R2: Opcode `0011` with function 2 (and), 3 (or), 5 (shift left) or 6 (shift right): ra=A, rb=B, rd=A, full write. Function 4 (not): rb=B, rd=A, full write, ra zero.
- R3: The 8-bit literal in [7:0] is used by opcodes `0010` (add), `0100` (sub), `0110` (load high byte), `0111` (load low byte) and `1100` (compare), and use_imm is 1 for all five. Add and sub: ra=rd=A, literal zero-extended, full write. Load high byte: literal in [15:8], mask 10. Load low byte: literal in [7:0], mask 01. Compare: ra=A, no write.
- R4: Opcodes `1000` (taken when flag set) and `1001` (taken when flag clear, br_inv=1) assert br. The flag selector in [11:10] drives the one-hot br_flag: 00→bit0 zero, 01→bit1 carry, 10→bit2 negative, 11→bit3 overflow. The immediate is [9:0] sign-extended.
- R5: Opcode `1101` jumps to [11:0], zero-extended onto imm. Opcode `0001` function 8, and opcode `1010` (return), jump through register A: ra=A, jmp and jmp_reg set. Bits [7:0] of a return are ignored.
- R6: Opcode `0001` function 9 (link): ra=R1 (target), rd=A, full write, jmp, jmp_reg and link set.
- R7: Opcode `0001` function 10 (load): ra=B as address, rd=A, mem_re, full write. Function 11 (store): ra=A as address, rb=B as data, mem_we.
- R8: Opcode `1110` (load direct) writes rd = 12 + [11:10] with mem_re and a full write. Opcode `0101` (store direct) reads rb = 12 + [11:10] with mem_we. Both put [9:0] zero-extended on imm.
- R9: The all-zero word is a no-op: every output zero, illegal clear. Any other word with opcode `0000` is illegal.
- R10: Opcodes `1011` and `1111`, and unlisted functions under `0001` and `0011`, set illegal and force every other output to zero. Exactly 48385 of the 65536 words are legal.
- R11: mem_re and mem_we are never both set. rf_wmask is nonzero exactly when rf_we is set. jmp_reg implies jmp. link implies rf_we and jmp. br_flag is one-hot when br is set and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word to decode |
| ra_o | output | 4 | First read register select |
| rb_o | output | 4 | Second read register select |
| rd_o | output | 4 | Write register select |
| imm_o | output | 16 | Immediate, offset, target or direct address |
| alu_op_o | output | 4 | ALU function code |
| use_imm_o | output | 1 | ALU second operand comes from imm_o |
| rf_we_o | output | 1 | Register file write enable |
| rf_wmask_o | output | 2 | Byte lanes written (bit1 upper, bit0 lower) |
| mem_re_o | output | 1 | Data memory read |
| mem_we_o | output | 1 | Data memory write |
| br_o | output | 1 | Conditional relative branch |
| br_inv_o | output | 1 | Branch taken when selected flag is clear |
| br_flag_o | output | 4 | One-hot flag select: zero, carry, negative, overflow |
| jmp_o | output | 1 | Unconditional jump |
| jmp_reg_o | output | 1 | Jump target is taken from register ra |
| link_o | output | 1 | Write return address to rd |
| illegal_o | output | 1 | Word is not an assigned encoding |

## Verification
Checks on every evaluation of the decoder cover the structural invariants: an illegal word stays quiet, memory read and write are exclusive, the lane mask agrees with the write enable, a register jump is a jump, a link writes, and the branch flag select is one-hot only on branches. Those checks cannot tell whether a particular opcode maps to the right fields and codes. The bench's vector table shows that mapping for each instruction, including the branch offset at both sign edges and the R12–R15 direct forms. An exhaustive sweep of all words confirms the exact size of the legal set.

// File: rtl/rr16_dec_pkg.sv
package rr16_dec_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int FN_W    = 4;
  localparam int REG_AW  = 4;

  typedef enum logic [3:0] {
    ALU_NONE  = 4'd0,
    ALU_ADD   = 4'd1,
    ALU_SUB   = 4'd2,
    ALU_AND   = 4'd3,
    ALU_OR    = 4'd4,
    ALU_NOT   = 4'd5,
    ALU_SHL   = 4'd6,
    ALU_SHR   = 4'd7,
    ALU_PASSB = 4'd8,
    ALU_SLT   = 4'd9
  } alu_op_e;

  typedef enum logic [2:0] {
    IMM_ZERO, IMM_LO8, IMM_HI8, IMM_BR10S, IMM_ADR10, IMM_J12
  } imm_kind_e;

  // SRC_FIX: R1 for ra, R12..R15 pair for rb/rd
  typedef enum logic [1:0] {
    SRC_NONE, SRC_OP1, SRC_OP2, SRC_FIX
  } reg_src_e;

  typedef struct packed {
    reg_src_e  ra_src;
    reg_src_e  rb_src;
    reg_src_e  rd_src;
    imm_kind_e imm_kind;
    logic      rf_we;
    logic [1:0] wmask;
    logic      mem_re;
    logic      mem_we;
    logic      br;
    logic      br_inv;
    logic      jmp;
    logic      jmp_reg;
    logic      link;
    logic      use_imm;
    alu_op_e   alu;
    logic      illegal;
  } ctrl_t;

endpackage

// File: rtl/rr16_dec_ctrl.sv
module rr16_dec_ctrl
  import rr16_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic             tail_zero_i,
  output ctrl_t            ctrl_o
);

  function automatic ctrl_t alu_wr(alu_op_e op, reg_src_e a, reg_src_e b,
                                   imm_kind_e k, logic [1:0] m);
    ctrl_t c;
    c          = '0;
    c.ra_src   = a;
    c.rb_src   = b;
    c.rd_src   = SRC_OP1;
    c.imm_kind = k;
    c.rf_we    = 1'b1;
    c.wmask    = m;
    c.use_imm  = (k != IMM_ZERO);
    c.alu      = op;
    return c;
  endfunction

  always_comb begin
    ctrl_o = '0;
    case (opc_i)
      4'h0: ctrl_o.illegal = !tail_zero_i;
      4'h1: begin
        case (fn_i)
          4'h0: ctrl_o = alu_wr(ALU_ADD,   SRC_OP1,  SRC_OP2, IMM_ZERO, 2'b11);
          4'h1: ctrl_o = alu_wr(ALU_SUB,   SRC_OP1,  SRC_OP2, IMM_ZERO, 2'b11);
          4'h7: ctrl_o = alu_wr(ALU_PASSB, SRC_NONE, SRC_OP2, IMM_ZERO, 2'b11);
          4'h8: begin
            ctrl_o.ra_src  = SRC_OP1;
            ctrl_o.jmp     = 1'b1;
            ctrl_o.jmp_reg = 1'b1;
          end
          4'h9: begin
            ctrl_o.ra_src  = SRC_FIX;
            ctrl_o.rd_src  = SRC_OP1;
            ctrl_o.rf_we   = 1'b1;
            ctrl_o.wmask   = 2'b11;
            ctrl_o.jmp     = 1'b1;
            ctrl_o.jmp_reg = 1'b1;
            ctrl_o.link    = 1'b1;
          end
          4'hA: begin
            ctrl_o.ra_src = SRC_OP2;
            ctrl_o.rd_src = SRC_OP1;
            ctrl_o.rf_we  = 1'b1;
            ctrl_o.wmask  = 2'b11;
            ctrl_o.mem_re = 1'b1;
          end
          4'hB: begin
            ctrl_o.ra_src = SRC_OP1;
            ctrl_o.rb_src = SRC_OP2;
            ctrl_o.mem_we = 1'b1;
          end
          4'hC: begin
            ctrl_o.ra_src = SRC_OP1;
            ctrl_o.rb_src = SRC_OP2;
            ctrl_o.alu    = ALU_SLT;
          end
          default: ctrl_o.illegal = 1'b1;
        endcase
      end
      4'h3: begin
        case (fn_i)
          4'h2: ctrl_o = alu_wr(ALU_AND, SRC_OP1,  SRC_OP2, IMM_ZERO, 2'b11);
          4'h3: ctrl_o = alu_wr(ALU_OR,  SRC_OP1,  SRC_OP2, IMM_ZERO, 2'b11);
          4'h4: ctrl_o = alu_wr(ALU_NOT, SRC_NONE, SRC_OP2, IMM_ZERO, 2'b11);
          4'h5: ctrl_o = alu_wr(ALU_SHL, SRC_OP1,  SRC_OP2, IMM_ZERO, 2'b11);
          4'h6: ctrl_o = alu_wr(ALU_SHR, SRC_OP1,  SRC_OP2, IMM_ZERO, 2'b11);
          default: ctrl_o.illegal = 1'b1;
        endcase
      end
      4'h2: ctrl_o = alu_wr(ALU_ADD,   SRC_OP1,  SRC_NONE, IMM_LO8, 2'b11);
      4'h4: ctrl_o = alu_wr(ALU_SUB,   SRC_OP1,  SRC_NONE, IMM_LO8, 2'b11);
      4'h6: ctrl_o = alu_wr(ALU_PASSB, SRC_NONE, SRC_NONE, IMM_HI8, 2'b10);
      4'h7: ctrl_o = alu_wr(ALU_PASSB, SRC_NONE, SRC_NONE, IMM_LO8, 2'b01);
      4'hC: begin
        ctrl_o.ra_src   = SRC_OP1;
        ctrl_o.imm_kind = IMM_LO8;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.alu      = ALU_SLT;
      end
      4'h8, 4'h9: begin
        ctrl_o.br       = 1'b1;
        ctrl_o.br_inv   = opc_i[0];
        ctrl_o.imm_kind = IMM_BR10S;
      end
      4'hA: begin
        ctrl_o.ra_src  = SRC_OP1;
        ctrl_o.jmp     = 1'b1;
        ctrl_o.jmp_reg = 1'b1;
      end
      4'hD: begin
        ctrl_o.imm_kind = IMM_J12;
        ctrl_o.jmp      = 1'b1;
      end
      4'hE: begin
        ctrl_o.rd_src   = SRC_FIX;
        ctrl_o.imm_kind = IMM_ADR10;
        ctrl_o.rf_we    = 1'b1;
        ctrl_o.wmask    = 2'b11;
        ctrl_o.mem_re   = 1'b1;
      end
      4'h5: begin
        ctrl_o.rb_src   = SRC_FIX;
        ctrl_o.imm_kind = IMM_ADR10;
        ctrl_o.mem_we   = 1'b1;
      end
      default: ctrl_o.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/rr16_dec_operands.sv
module rr16_dec_operands
  import rr16_dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  reg_src_e           ra_src_i,
  input  reg_src_e           rb_src_i,
  input  reg_src_e           rd_src_i,
  input  imm_kind_e          imm_kind_i,
  output logic [REG_AW-1:0]  ra_o,
  output logic [REG_AW-1:0]  rb_o,
  output logic [REG_AW-1:0]  rd_o,
  output logic [DATA_W-1:0]  imm_o
);

  localparam int LIT_W  = 8;
  localparam int OFF_W  = 10;
  localparam int TGT_W  = 12;
  localparam int PAIR_W = 2;
  localparam logic [REG_AW-1:0] LINK_SRC = REG_AW'(1);
  localparam logic [REG_AW-PAIR_W-1:0] HIGH_BASE = '1;

  logic [REG_AW-1:0] op1, op2, high_reg;
  logic [LIT_W-1:0]  lit;
  logic [OFF_W-1:0]  off;
  logic [TGT_W-1:0]  tgt;

  assign op1      = instr_i[11:8];
  assign op2      = instr_i[7:4];
  assign high_reg = {HIGH_BASE, instr_i[11:10]};
  assign lit      = instr_i[LIT_W-1:0];
  assign off      = instr_i[OFF_W-1:0];
  assign tgt      = instr_i[TGT_W-1:0];

  function automatic logic [REG_AW-1:0] pick(reg_src_e s, logic [REG_AW-1:0] fix,
                                             logic [REG_AW-1:0] a, logic [REG_AW-1:0] b);
    case (s)
      SRC_OP1: return a;
      SRC_OP2: return b;
      SRC_FIX: return fix;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    ra_o = pick(ra_src_i, LINK_SRC, op1, op2);
    rb_o = pick(rb_src_i, high_reg, op1, op2);
    rd_o = pick(rd_src_i, high_reg, op1, op2);
  end

  always_comb begin
    case (imm_kind_i)
      IMM_LO8:   imm_o = DATA_W'(lit);
      IMM_HI8:   imm_o = DATA_W'(lit) << LIT_W;
      IMM_BR10S: imm_o = DATA_W'(signed'(off));
      IMM_ADR10: imm_o = DATA_W'(off);
      IMM_J12:   imm_o = DATA_W'(tgt);
      default:   imm_o = '0;
    endcase
  end

endmodule

// File: rtl/rr16_decoder.sv
module rr16_decoder
  import rr16_dec_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_FLAGS = 4
) (
  input  logic [INSTR_W-1:0]   instr_i,
  output logic [REG_AW-1:0]    ra_o,
  output logic [REG_AW-1:0]    rb_o,
  output logic [REG_AW-1:0]    rd_o,
  output logic [DATA_W-1:0]    imm_o,
  output logic [3:0]           alu_op_o,
  output logic                 use_imm_o,
  output logic                 rf_we_o,
  output logic [1:0]           rf_wmask_o,
  output logic                 mem_re_o,
  output logic                 mem_we_o,
  output logic                 br_o,
  output logic                 br_inv_o,
  output logic [NUM_FLAGS-1:0] br_flag_o,
  output logic                 jmp_o,
  output logic                 jmp_reg_o,
  output logic                 link_o,
  output logic                 illegal_o
);

  localparam int FSEL_W = $clog2(NUM_FLAGS);

  ctrl_t ctrl;

  rr16_dec_ctrl u_ctrl (
    .opc_i       (instr_i[15:12]),
    .fn_i        (instr_i[3:0]),
    .tail_zero_i (instr_i[11:0] == '0),
    .ctrl_o      (ctrl)
  );

  rr16_dec_operands #(.DATA_W(DATA_W)) u_opnd (
    .instr_i    (instr_i),
    .ra_src_i   (ctrl.ra_src),
    .rb_src_i   (ctrl.rb_src),
    .rd_src_i   (ctrl.rd_src),
    .imm_kind_i (ctrl.imm_kind),
    .ra_o       (ra_o),
    .rb_o       (rb_o),
    .rd_o       (rd_o),
    .imm_o      (imm_o)
  );

  generate
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      assign br_flag_o[g] = ctrl.br && (instr_i[11 -: FSEL_W] == FSEL_W'(g));
    end
  endgenerate

  assign alu_op_o   = ctrl.alu;
  assign use_imm_o  = ctrl.use_imm;
  assign rf_we_o    = ctrl.rf_we;
  assign rf_wmask_o = ctrl.wmask;
  assign mem_re_o   = ctrl.mem_re;
  assign mem_we_o   = ctrl.mem_we;
  assign br_o       = ctrl.br;
  assign br_inv_o   = ctrl.br_inv;
  assign jmp_o      = ctrl.jmp;
  assign jmp_reg_o  = ctrl.jmp_reg;
  assign link_o     = ctrl.link;
  assign illegal_o  = ctrl.illegal;

  always_comb begin
    if (!$isunknown(instr_i)) begin
      // R10
      illegal_quiet_chk: assert (!illegal_o ||
        ({ra_o, rb_o, rd_o, imm_o, alu_op_o, use_imm_o, rf_we_o, rf_wmask_o,
          mem_re_o, mem_we_o, br_o, br_inv_o, br_flag_o, jmp_o, jmp_reg_o, link_o} == '0));
      // R11
      mem_excl_chk: assert (!(mem_re_o && mem_we_o));
      // R11
      wmask_match_chk: assert (rf_we_o == (rf_wmask_o != 2'b00));
      // R5
      jmp_reg_chk: assert (!jmp_reg_o || jmp_o);
      // R6
      link_write_chk: assert (!link_o || (rf_we_o && jmp_o && jmp_reg_o));
      // R4
      flag_onehot_chk: assert (br_o ? ($countones(br_flag_o) == 1) : (br_flag_o == '0));
    end
  end

endmodule

// File: tb/rr16_decoder_tb.sv
module rr16_decoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] instr;
  logic [3:0]  ra, rb, rd, alu, flag;
  logic [15:0] imm;
  logic        uimm, we, mre, mwe, br, binv, jmp, jreg, link, ill;
  logic [1:0]  mask;

  rr16_decoder dut_i (
    .instr_i(instr), .ra_o(ra), .rb_o(rb), .rd_o(rd), .imm_o(imm),
    .alu_op_o(alu), .use_imm_o(uimm), .rf_we_o(we), .rf_wmask_o(mask),
    .mem_re_o(mre), .mem_we_o(mwe), .br_o(br), .br_inv_o(binv),
    .br_flag_o(flag), .jmp_o(jmp), .jmp_reg_o(jreg), .link_o(link),
    .illegal_o(ill)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // {req, instr, ra rb rd, imm, alu, {uimm,we,mask}, {mre,mwe,br,binv}, flag, {jmp,jreg,link,ill}}
  localparam int NV = 33;
  localparam logic [67:0] VEC [NV] = '{
    68'h9_0000_000_0000_0_0_0_0_0, // R9 no-op
    68'h1_1180_181_0000_1_7_0_0_0, // R1 add
    68'h1_1231_232_0000_2_7_0_0_0, // R1 sub
    68'h1_1957_059_0000_8_7_0_0_0, // R1 move
    68'h1_118C_180_0000_9_0_0_0_0, // R1 compare
    68'h2_3242_242_0000_3_7_0_0_0, // R2 and
    68'h2_3243_242_0000_4_7_0_0_0, // R2 or
    68'h2_3244_042_0000_5_7_0_0_0, // R2 not
    68'h2_3245_242_0000_6_7_0_0_0, // R2 shl
    68'h2_3246_242_0000_7_7_0_0_0, // R2 shr
    68'h3_23F2_303_00F2_1_F_0_0_0, // R3 addi
    68'h3_43F2_303_00F2_2_F_0_0_0, // R3 subi
    68'h3_692E_009_2E00_8_E_0_0_0, // R3 high byte
    68'h3_792E_009_002E_8_D_0_0_0, // R3 low byte
    68'h3_C10C_100_000C_9_8_0_0_0, // R3 compare imm
    68'h4_8269_000_FE69_0_0_2_1_0, // R4 zero, negative offset
    68'h4_9405_000_0005_0_0_3_2_0, // R4 carry, inverted
    68'h4_89FF_000_01FF_0_0_2_4_0, // R4 negative, max positive
    68'h4_9E00_000_FE00_0_0_3_8_0, // R4 overflow, min negative
    68'h5_1308_300_0000_0_0_0_0_C, // R5 jump via register
    68'h5_A3C7_300_0000_0_0_0_0_C, // R5 return, low byte ignored
    68'h5_DF0B_000_0F0B_0_0_0_0_8, // R5 absolute
    68'h6_1309_103_0000_0_7_0_0_E, // R6 link
    68'h7_195A_509_0000_0_7_8_0_0, // R7 load
    68'h7_195B_950_0000_0_0_4_0_0, // R7 store
    68'h8_E8CC_00E_00CC_0_7_8_0_0, // R8 load direct R14
    68'h8_54CC_0D0_00CC_0_0_4_0_0, // R8 store direct R13
    68'hA_B123_000_0000_0_0_0_0_1, // R10 opcode 1011
    68'hA_FFFF_000_0000_0_0_0_0_1, // R10 opcode 1111
    68'hA_100D_000_0000_0_0_0_0_1, // R10 unlisted fn
    68'hA_3201_000_0000_0_0_0_0_1, // R10 unlisted fn
    68'hA_3207_000_0000_0_0_0_0_1, // R10 unlisted fn
    68'h9_0001_000_0000_0_0_0_0_1  // R9 nonzero under 0000
  };

  function automatic logic [47:0] observed();
    return {ra, rb, rd, imm, alu, uimm, we, mask, mre, mwe, br, binv, flag,
            jmp, jreg, link, ill};
  endfunction

  task automatic check(bit ok, int req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] w);
    @(negedge clk);
    instr = w;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int legal;
    int bad_quiet;
    int bad_inv;
    instr = 16'h0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R9: quiet outputs for the no-op word held through reset
    check(observed() == 48'h0, 9, 64'(observed()), 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][63:48]);
      check(observed() == VEC[i][47:0], int'(VEC[i][67:64]),
            64'(observed()), 64'(VEC[i][47:0]));
    end

    // R10 / R11 exhaustive sweep
    legal = 0;
    bad_quiet = 0;
    bad_inv = 0;
    for (int w = 0; w < 65536; w++) begin
      apply(16'(w));
      if (!ill) legal++;
      else if (observed() != 48'h1) bad_quiet++;
      if ((mre && mwe) || (we != (mask != 2'b00)) || (jreg && !jmp)) bad_inv++;
    end
    check(legal == 48385, 10, 64'(legal), 64'd48385);   // R10 legal set size
    check(bad_quiet == 0, 10, 64'(bad_quiet), 64'd0);   // R10 quiet when illegal
    check(bad_inv == 0, 11, 64'(bad_inv), 64'd0);       // R11 invariants
    finish_run();
  end

endmodule